// File: doc/BRIEF.md
# Two-Bank SDRAM Write Command Sequencer

This block turns host write requests into SDRAM command-bus traffic for a device with two banks and a 16-bit data bus. A request names a bank, a row, a starting column and whether the bank should close by itself when the burst is done. The sequencer opens and closes rows as needed, issues the write, and pulls burst data from the host one word per cycle. Each bank keeps its own timers for the activate-to-write delay, the write-recovery delay and the precharge delay. Each bank also keeps its own lock while a self-closing write is pending.

A new request is taken as soon as the previous write command has gone out. Its precharge or activate can therefore be issued while the earlier burst is still on the data bus. A write to the other bank is not held up while one bank is recovering or closing. The burst length comes from a static configuration input, and so does a single-word write mode. Reads, refresh, mode programming and power-up are outside this block.

The controller states are S_IDLE, S_CLOSE, S_OPEN, S_WRITE and S_FLUSH. The transitions are:
- S_IDLE to S_WRITE on a row hit.
- S_IDLE to S_CLOSE on a row miss.
- S_IDLE to S_OPEN when the bank is closed or is closing itself.
- S_CLOSE to S_OPEN once PRE is issued.
- S_OPEN to S_WRITE once ACT is issued.
- S_WRITE to S_IDLE once the write is issued, or to S_FLUSH when a full-page burst asked to close itself.
- S_FLUSH to S_IDLE once its PRE is issued.

Top module: `sdw_seq`

## Requirements
- R1: A WRITE to a bank is issued no sooner than TRCD cycles after that bank's ACT. When nothing else holds it back, it is issued exactly TRCD cycles after.
- R2: The first data word appears on `dq_o` with `dq_oe_o` high in the same cycle as the WRITE. The remaining words follow on consecutive cycles.
- R3: The burst length is set by `cfg_blen_i`. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 words. Any code of 4 or more gives a full page of 256 words. The WRITE address bits 7..0 carry the start column.
- R4: `cmd_o` uses the codes NOP=0, ACT=1, WRITE=2 and PRE=3. ACT carries the row on `addr_o`. WRITE carries the auto-close flag on address bit 8. PRE drives address 0.
- R5: A PRE to a bank comes no sooner than TWR cycles after that bank's last data word. When it is already waiting, it comes exactly TWR cycles after.
- R6: After a self-closing write, the next ACT to that bank comes exactly TWR+TRP cycles after the last word when it is already waiting, and never sooner.
- R7: While a self-closing write is pending, no command is issued to that bank.
- R8: A write to the other bank proceeds during that lockout. Its first word follows the previous burst's last word with no gap.
- R9: A self-closing request with a full-page burst is issued as a plain WRITE (bit 8 low). An explicit PRE follows exactly TWR cycles after the last word.
- R10: With `cfg_single_i` high, every write moves exactly one word, whatever `cfg_blen_i` holds, and the auto-close flag is kept.
- R11: On a row miss, the order is PRE, then ACT no sooner than TRP cycles later, then WRITE. Each step is exact when it is the only thing waiting.
- R12: In reset and on every cycle without a legal command, `cmd_o` is NOP. `dq_oe_o` is low outside bursts. `req_ready_o` is high in reset.
- R13: A request is taken on a cycle with `req_valid_i` and `req_ready_o` both high, after which `req_ready_o` drops. `wd_take_o` is high on exactly the data-word cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blen_i | input | 3 | Burst-length code |
| cfg_single_i | input | 1 | Single-word write mode |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Sequencer can take a request |
| req_bank_i | input | 1 | Target bank |
| req_row_i | input | ADDR_W | Target row |
| req_col_i | input | COL_W | Start column |
| req_ap_i | input | 1 | Close the bank after the burst |
| wdata_i | input | DQ_W | Host word to be written next |
| wd_take_o | output | 1 | Host word consumed this cycle |
| cmd_o | output | 2 | SDRAM command code |
| ba_o | output | 1 | Bank select |
| addr_o | output | ADDR_W | SDRAM address lines |
| dq_o | output | DQ_W | Write data |
| dq_oe_o | output | 1 | Data bus driven |

## Verification
The latencies the bench expects are as follows:
- Data: the first word lands in the WRITE cycle itself, and the last word lands length-1 cycles later.
- Write after activate: the WRITE follows its ACT by TRCD cycles.
- Precharge after a burst: a waiting PRE follows the last word by TWR cycles.
- Activate after precharge: a waiting ACT follows an explicit PRE by TRP cycles, or follows a self-closing burst's last word by TWR+TRP cycles.
- Back-to-back bursts: a second burst starts on the cycle after the previous last word.

The scoreboard stamps every command and every burst end with a cycle number taken at the falling edge. Requests are queued back to back so that the controller is already waiting when each timer expires. Each gap is then compared against these exact counts, not against lower bounds.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_ACT   = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_PRE   = 2'd3
    } sdw_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CLOSE = 3'd1,
        S_OPEN  = 3'd2,
        S_WRITE = 3'd3,
        S_FLUSH = 3'd4
    } sdw_state_e;

endpackage

// File: rtl/sdw_bank.sv
module sdw_bank #(
    parameter int ROW_W = 9,
    parameter int TRCD  = 2,
    parameter int TWR   = 2,
    parameter int TRP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             wr_i,
    input  logic             ap_i,
    input  logic             pre_i,
    input  logic             last_i,
    input  logic             busy_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             can_act_o,
    output logic             can_wr_o,
    output logic             can_pre_o
);
    localparam int TMAX = (TRCD > TWR) ? ((TRCD > TRP) ? TRCD : TRP)
                                       : ((TWR > TRP) ? TWR : TRP);
    localparam int CW = $clog2(TMAX + 1);

    logic             open_q, ap_q;
    logic [ROW_W-1:0] row_q;
    logic [CW-1:0]    rcd_q, wrc_q, rpc_q;
    logic             ap_close;

    // self-close fires TWR cycles after the last word of this bank's burst
    assign ap_close = ap_q && !busy_i && !last_i && (wrc_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            ap_q   <= 1'b0;
            row_q  <= '0;
            rcd_q  <= '0;
            wrc_q  <= '0;
            rpc_q  <= '0;
        end else begin
            if (act_i) begin
                open_q <= 1'b1;
                row_q  <= row_i;
            end else if (pre_i || ap_close) begin
                open_q <= 1'b0;
            end
            if (act_i)              rcd_q <= CW'(TRCD - 1);
            else if (rcd_q != '0)   rcd_q <= rcd_q - 1'b1;
            if (last_i)             wrc_q <= CW'(TWR - 1);
            else if (wrc_q != '0)   wrc_q <= wrc_q - 1'b1;
            if (pre_i || ap_close)  rpc_q <= CW'(TRP - 1);
            else if (rpc_q != '0)   rpc_q <= rpc_q - 1'b1;
            if (wr_i && ap_i)       ap_q  <= 1'b1;
            else if (ap_close)      ap_q  <= 1'b0;
        end
    end

    assign open_o    = open_q && !ap_q;
    assign row_o     = row_q;
    assign can_act_o = !open_q && !ap_q && (rpc_q == '0);
    assign can_wr_o  = open_q && !ap_q && (rcd_q == '0);
    assign can_pre_o = open_q && !ap_q && !busy_i && !last_i && (wrc_q == '0);
endmodule

// File: rtl/sdw_beat.sv
module sdw_beat #(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             bank_i,
    output logic             beat_o,
    output logic             last_o,
    output logic             bank_o,
    output logic             active_o,
    output logic             cur_bank_o
);
    logic [LEN_W-1:0] rem_q;
    logic             act_q, bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            act_q  <= 1'b0;
            bank_q <= 1'b0;
        end else if (start_i) begin
            bank_q <= bank_i;
            act_q  <= (len_i > LEN_W'(1));
            rem_q  <= len_i - 1'b1;
        end else if (act_q) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) act_q <= 1'b0;
        end
    end

    assign beat_o     = start_i || act_q;
    assign bank_o     = start_i ? bank_i : bank_q;
    assign last_o     = start_i ? (len_i == LEN_W'(1)) : (act_q && rem_q == LEN_W'(1));
    assign active_o   = act_q;
    assign cur_bank_o = bank_q;
endmodule

// File: rtl/sdw_seq.sv
module sdw_seq
    import sdw_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int COL_W  = 8,
    parameter int DQ_W   = 16,
    parameter int TRCD   = 2,
    parameter int TWR    = 2,
    parameter int TRP    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_blen_i,
    input  logic              cfg_single_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_bank_i,
    input  logic [ADDR_W-1:0] req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    input  logic              req_ap_i,
    input  logic [DQ_W-1:0]   wdata_i,
    output logic              wd_take_o,
    output logic [1:0]        cmd_o,
    output logic              ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DQ_W-1:0]   dq_o,
    output logic              dq_oe_o
);
    localparam int NBANK = 2;
    localparam int LEN_W = COL_W + 1;
    localparam int AP_BIT = COL_W;
    localparam logic [LEN_W-1:0] FULL_LEN = {1'b1, {COL_W{1'b0}}};

    sdw_state_e state_q, state_d;
    logic              q_bank, q_ap;
    logic [ADDR_W-1:0] q_row;
    logic [COL_W-1:0]  q_col;

    logic              bk_open    [NBANK];
    logic [ADDR_W-1:0] bk_row     [NBANK];
    logic              bk_can_act [NBANK];
    logic              bk_can_wr  [NBANK];
    logic              bk_can_pre [NBANK];

    logic act_fire, wr_fire, pre_fire, wr_ap;
    logic beat, beat_last, beat_bank, beat_active, beat_cur_bank;
    logic fp_eff;
    logic [LEN_W-1:0] blen;

    // effective burst length; a full page cannot close itself
    assign fp_eff = cfg_blen_i[2] && !cfg_single_i;
    always_comb begin
        if (cfg_single_i)       blen = LEN_W'(1);
        else if (cfg_blen_i[2]) blen = FULL_LEN;
        else                    blen = LEN_W'(1) << cfg_blen_i[1:0];
    end
    assign wr_ap = q_ap && !fp_eff;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdw_bank #(
            .ROW_W (ADDR_W),
            .TRCD  (TRCD),
            .TWR   (TWR),
            .TRP   (TRP)
        ) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act_fire && q_bank == 1'(b)),
            .row_i     (q_row),
            .wr_i      (wr_fire && q_bank == 1'(b)),
            .ap_i      (wr_ap),
            .pre_i     (pre_fire && q_bank == 1'(b)),
            .last_i    (beat_last && beat_bank == 1'(b)),
            .busy_i    (beat_active && beat_cur_bank == 1'(b)),
            .open_o    (bk_open[b]),
            .row_o     (bk_row[b]),
            .can_act_o (bk_can_act[b]),
            .can_wr_o  (bk_can_wr[b]),
            .can_pre_o (bk_can_pre[b])
        );
    end

    sdw_beat #(.LEN_W(LEN_W)) beat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (wr_fire),
        .len_i      (blen),
        .bank_i     (q_bank),
        .beat_o     (beat),
        .last_o     (beat_last),
        .bank_o     (beat_bank),
        .active_o   (beat_active),
        .cur_bank_o (beat_cur_bank)
    );

    // state register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            q_bank  <= 1'b0;
            q_row   <= '0;
            q_col   <= '0;
            q_ap    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid_i) begin
                q_bank <= req_bank_i;
                q_row  <= req_row_i;
                q_col  <= req_col_i;
                q_ap   <= req_ap_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid_i) begin
                if (!bk_open[req_bank_i])                    state_d = S_OPEN;
                else if (bk_row[req_bank_i] == req_row_i)    state_d = S_WRITE;
                else                                         state_d = S_CLOSE;
            end
            S_CLOSE: if (bk_can_pre[q_bank]) state_d = S_OPEN;
            S_OPEN:  if (bk_can_act[q_bank]) state_d = S_WRITE;
            S_WRITE: if (bk_can_wr[q_bank] && !beat_active)
                         state_d = (q_ap && fp_eff) ? S_FLUSH : S_IDLE;
            S_FLUSH: if (bk_can_pre[q_bank]) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // command outputs
    always_comb begin
        act_fire = 1'b0;
        wr_fire  = 1'b0;
        pre_fire = 1'b0;
        cmd_o    = CMD_NOP;
        addr_o   = '0;
        unique case (state_q)
            S_IDLE: ;
            S_CLOSE, S_FLUSH: if (bk_can_pre[q_bank]) begin
                pre_fire = 1'b1;
                cmd_o    = CMD_PRE;
            end
            S_OPEN: if (bk_can_act[q_bank]) begin
                act_fire = 1'b1;
                cmd_o    = CMD_ACT;
                addr_o   = q_row;
            end
            S_WRITE: if (bk_can_wr[q_bank] && !beat_active) begin
                wr_fire               = 1'b1;
                cmd_o                 = CMD_WRITE;
                addr_o[COL_W-1:0]     = q_col;
                addr_o[AP_BIT]        = wr_ap;
            end
            default: ;
        endcase
    end

    assign ba_o        = (cmd_o != CMD_NOP) ? q_bank : 1'b0;
    assign req_ready_o = (state_q == S_IDLE);
    assign wd_take_o   = beat;
    assign dq_oe_o     = beat;
    assign dq_o        = beat ? wdata_i : '0;
endmodule

// File: rtl/sdw_chk.sv
module sdw_chk
    import sdw_pkg::*;
#(
    parameter int TRCD = 2,
    parameter int TWR  = 2,
    parameter int TRP  = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_o,
    input logic       ba_o,
    input logic       dq_oe_o,
    input logic       req_ready_o
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] since_act  [2];
    logic [15:0] since_beat [2];
    logic [15:0] since_pre  [2];
    logic        burst_bank_q;
    logic        beat_bank;

    assign beat_bank = (cmd_o == CMD_WRITE) ? ba_o : burst_bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_bank_q <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                since_act[b]  <= '0;
                since_beat[b] <= SAT;
                since_pre[b]  <= SAT;
            end
        end else begin
            if (cmd_o == CMD_WRITE) burst_bank_q <= ba_o;
            for (int b = 0; b < 2; b++) begin
                if (cmd_o == CMD_ACT && ba_o == 1'(b)) since_act[b] <= 16'd1;
                else if (since_act[b] != SAT)          since_act[b] <= since_act[b] + 1'b1;
                if (dq_oe_o && beat_bank == 1'(b))     since_beat[b] <= 16'd1;
                else if (since_beat[b] != SAT)         since_beat[b] <= since_beat[b] + 1'b1;
                if (cmd_o == CMD_PRE && ba_o == 1'(b)) since_pre[b] <= 16'd1;
                else if (since_pre[b] != SAT)          since_pre[b] <= since_pre[b] + 1'b1;
            end
        end
    end

    a_r1_trcd_met: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_WRITE) |-> (since_act[ba_o] >= 16'(TRCD)));

    a_r2_data_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_WRITE) |-> dq_oe_o);

    a_r5_twr_met: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE) |-> (since_beat[ba_o] >= 16'(TWR)));

    a_r11_trp_met: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT) |-> (since_pre[ba_o] >= 16'(TRP)));

    a_r12_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (cmd_o == CMD_NOP));
endmodule

bind sdw_seq sdw_chk #(.TRCD(TRCD), .TWR(TWR), .TRP(TRP)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_o       (cmd_o),
    .ba_o        (ba_o),
    .dq_oe_o     (dq_oe_o),
    .req_ready_o (req_ready_o)
);

// File: tb/sdw_seq_tb_top.sv
module sdw_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 9;
    localparam int COL_W  = 8;
    localparam int DQ_W   = 16;
    localparam int TRCD   = 2;
    localparam int TWR    = 2;
    localparam int TRP    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_blen_i = 3'd2;
    logic              cfg_single_i = 1'b0;
    logic              req_valid_i = 1'b0;
    logic              req_ready_o;
    logic              req_bank_i = 1'b0;
    logic [ADDR_W-1:0] req_row_i = '0;
    logic [COL_W-1:0]  req_col_i = '0;
    logic              req_ap_i = 1'b0;
    logic [DQ_W-1:0]   wdata_i = '0;
    logic              wd_take_o;
    logic [1:0]        cmd_o;
    logic              ba_o;
    logic [ADDR_W-1:0] addr_o;
    logic [DQ_W-1:0]   dq_o;
    logic              dq_oe_o;

    sdw_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DQ_W(DQ_W),
              .TRCD(TRCD), .TWR(TWR), .TRP(TRP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_blen_i(cfg_blen_i), .cfg_single_i(cfg_single_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_bank_i(req_bank_i),
        .req_row_i(req_row_i), .req_col_i(req_col_i), .req_ap_i(req_ap_i),
        .wdata_i(wdata_i), .wd_take_o(wd_take_o), .cmd_o(cmd_o), .ba_o(ba_o),
        .addr_o(addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int cmd; int ba; int addr; int len; } exp_t;
    exp_t        exp_q[$];
    logic [15:0] data_q[$];
    logic [15:0] feed_q[$];
    int lg_cmd[$], lg_ba[$], lg_cyc[$], lg_end[$];
    int n_tests = 0, n_fail = 0;
    int m_open[2] = '{0, 0};
    int m_row[2]  = '{0, 0};
    int tb_blen = 2, tb_single = 0;
    logic [15:0] seed = 16'hA000;
    bit done = 0;

    task automatic chk(string req, int actual, int expv, string what);
        n_tests++;
        if (actual != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, actual, expv);
        end
    endtask

    // driver: model the bank state, push expected commands and words, handshake
    task automatic send(int b, int row, int col, int ap);
        int len;
        int fp;
        int ap_eff;
        fp     = (tb_blen >= 4 && tb_single == 0);
        len    = tb_single ? 1 : (tb_blen >= 4 ? 256 : (1 << tb_blen));
        ap_eff = ap && !fp;
        if (m_open[b] && m_row[b] != row) exp_q.push_back('{3, b, 0, 0});
        if (!m_open[b] || m_row[b] != row) exp_q.push_back('{1, b, row, 0});
        exp_q.push_back('{2, b, (ap_eff << 8) | col, len});
        if (ap && fp) exp_q.push_back('{3, b, 0, 0});
        m_open[b] = ap ? 0 : 1;
        m_row[b]  = row;
        for (int i = 0; i < len; i++) begin
            data_q.push_back(seed);
            feed_q.push_back(seed);
            seed = seed + 16'h0101;
        end
        req_bank_i  = 1'(b);
        req_row_i   = ADDR_W'(row);
        req_col_i   = COL_W'(col);
        req_ap_i    = 1'(ap);
        req_valid_i = 1'b1;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R13", int'(req_ready_o), 0, "ready after accept");
    endtask

    task automatic wait_quiet();
        while (exp_q.size() != 0 || data_q.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // host data feed
    initial begin
        logic tk;
        forever begin
            @(negedge clk);
            tk = wd_take_o;
            @(posedge clk);
            if (tk && feed_q.size() != 0) void'(feed_q.pop_front());
            #1 wdata_i = (feed_q.size() != 0) ? feed_q[0] : '0;
        end
    end

    // monitor / scoreboard
    initial begin
        int rem = 0;
        int widx = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (cmd_o != 2'd0) begin
                    lg_cmd.push_back(int'(cmd_o));
                    lg_ba.push_back(int'(ba_o));
                    lg_cyc.push_back(cyc);
                    lg_end.push_back(-1);
                    if (exp_q.size() == 0) begin
                        chk("R12", int'(cmd_o), 0, "unexpected command");
                    end else begin
                        e = exp_q.pop_front();
                        chk("R4", int'(cmd_o), e.cmd, "command code");
                        chk("R7", int'(ba_o), e.ba, "bank select");
                        chk("R4", int'(addr_o), e.addr, "address lines");
                        if (cmd_o == 2'd2) begin
                            rem  = e.len;
                            widx = lg_cyc.size() - 1;
                        end
                    end
                end
                if (rem > 0 || dq_oe_o) begin
                    chk("R2", int'(dq_oe_o), int'(rem > 0), "data enable");
                    chk("R13", int'(wd_take_o), int'(rem > 0), "host take strobe");
                    if (rem > 0) begin
                        if (data_q.size() != 0)
                            chk("R2", int'(dq_o), int'(data_q.pop_front()), "data word");
                        rem--;
                        if (rem == 0) lg_end[widx] = cyc;
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        chk("R12", int'(cmd_o), 0, "reset command");
        chk("R12", int'(dq_oe_o), 0, "reset data enable");
        chk("R12", int'(req_ready_o), 1, "reset ready");
        rst_n = 1'b1;
        @(negedge clk);

        // T1: closed bank, activate then write, BL4
        b = lg_cyc.size();
        send(0, 5, 'h10, 0);
        wait_quiet();
        chk("R1", lg_cyc[b+1] - lg_cyc[b], TRCD, "ACT to WRITE gap");
        chk("R2", lg_end[b+1] - lg_cyc[b+1], 3, "BL4 burst span");

        // T2: self-closing write to bank 1, bank 0 hit during lockout, bank 1 reopened
        b = lg_cyc.size();
        send(1, 7, 'h20, 1);
        send(0, 5, 'h30, 0);
        send(1, 7, 'h40, 0);
        wait_quiet();
        chk("R8", lg_cyc[b+2], lg_end[b+1] + 1, "gapless other-bank write");
        chk("R7", lg_ba[b+2], 0, "only other bank during lockout");
        chk("R6", lg_cyc[b+3] - lg_end[b+1], TWR + TRP, "reopen after self-close");
        chk("R1", lg_cyc[b+4] - lg_cyc[b+3], TRCD, "ACT to WRITE after reopen");

        // T3: row miss right behind a hit on bank 0
        b = lg_cyc.size();
        send(0, 5, 'h50, 0);
        send(0, 9, 'h60, 0);
        wait_quiet();
        chk("R5", lg_cyc[b+1] - lg_end[b], TWR, "PRE after last word");
        chk("R11", lg_cyc[b+2] - lg_cyc[b+1], TRP, "ACT after PRE");
        chk("R11", lg_cyc[b+3] - lg_cyc[b+2], TRCD, "WRITE after miss ACT");

        // T4: single-word mode, BL4 then full-page code with auto-close kept
        cfg_single_i = 1'b1; tb_single = 1;
        b = lg_cyc.size();
        send(0, 9, 'h61, 0);
        wait_quiet();
        chk("R10", lg_end[b] - lg_cyc[b], 0, "single word with BL4");
        cfg_blen_i = 3'd4; tb_blen = 4;
        b = lg_cyc.size();
        send(0, 9, 'h62, 1);
        wait_quiet();
        chk("R10", lg_end[b] - lg_cyc[b], 0, "single word with full page code");
        cfg_single_i = 1'b0; tb_single = 0;

        // T5: full page with auto-close request is downgraded
        cfg_blen_i = 3'd7; tb_blen = 7;
        b = lg_cyc.size();
        send(1, 7, 0, 1);
        wait_quiet();
        chk("R9", lg_end[b] - lg_cyc[b], 255, "full page span");
        chk("R9", lg_cyc[b+1] - lg_end[b], TWR, "explicit PRE after full page");

        // T6: burst length codes 0, 1, 3
        cfg_blen_i = 3'd0; tb_blen = 0;
        b = lg_cyc.size();
        send(1, 3, 'h11, 0);
        wait_quiet();
        chk("R3", lg_end[b+1] - lg_cyc[b+1], 0, "BL1 span");
        cfg_blen_i = 3'd1; tb_blen = 1;
        b = lg_cyc.size();
        send(1, 3, 'h12, 0);
        wait_quiet();
        chk("R3", lg_end[b] - lg_cyc[b], 1, "BL2 span");
        cfg_blen_i = 3'd3; tb_blen = 3;
        b = lg_cyc.size();
        send(1, 3, 'h13, 0);
        wait_quiet();
        chk("R3", lg_end[b] - lg_cyc[b], 7, "BL8 span");
        chk("R12", int'(cmd_o), 0, "idle command");

        finish_run();
    end
endmodule